// File: doc/BRIEF.md
# Branch History and Instruction Counter

This block follows program flow between trace messages. It keeps a running count of the halfwords taken up by retired instructions. It also keeps a shift register of direct conditional branch outcomes, which sits below a single marker bit. A message serializer reads these fields when it emits a message. It then pulses an acknowledge, and the block hands back a snapshot of both fields and starts a new interval.

If the count gets close to the top of its range, or the history register runs out of room, the block flushes that resource on its own. It raises a resource-full report with a reason code that says which resource ran out. If both run out in the same cycle, two reports leave on consecutive cycles, counter first. A trace start or restart returns everything to its initial state.

Top module: `flow_track`

## Requirements
- R1: While `ret_valid` is high, each cycle adds 1 to `cur_icnt` for a compressed instruction (`ret_len32`=0) or 2 for a 32-bit instruction (`ret_len32`=1). When `ret_valid` is low the count holds.
- R2: `cur_hist` starts at 1, which is the marker bit alone. A retired instruction with `ret_kind`=5 (taken branch) shifts a 1 into bit 0, and `ret_kind`=4 (not-taken branch) shifts a 0 into bit 0, so the marker moves up one place. Any other `ret_kind` leaves the history unchanged.
- R3: A cycle with `msg_ack` high raises `snap_valid` for one cycle on the next edge. That snapshot carries the count and history held before that cycle. The new interval begins from 0 and 1, and an instruction retiring in the ack cycle is counted into the new interval.
- R4: When the count after this cycle's addition reaches 2^CNT_W-2 or more, the next edge gives `rf_valid`=1 and `rf_code`=0, with `rf_icnt` equal to that sum. `cur_icnt` returns to 0.
- R5: When a history shift sets bit HIST_W-1, the next edge gives `rf_valid`=1 and `rf_code`=1, with `rf_hist` equal to the shifted value. `cur_hist` returns to 1.
- R6: If R4 and R5 trigger in the same cycle, the code-0 report comes on the next edge and the code-1 report comes on the edge after it.
- R7: A cycle with `trace_start` high clears the count to 0 and the history to 1. It drops any pending report and raises neither `snap_valid` nor `rf_valid`. A retire or ack in that same cycle has no effect.
- R8: In an ack cycle the fresh interval holds only that cycle's instruction, so no resource-full report can be raised from that cycle.
- R9: After reset the count is 0, the history is 1, and `snap_valid` and `rf_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_start | input | 1 | Trace start or restart, synchronous clear |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_len32 | input | 1 | 1 for a 32-bit instruction, 0 for compressed |
| ret_kind | input | 4 | Instruction type; 4 is a not-taken branch, 5 is a taken branch |
| msg_ack | input | 1 | A message carrying the fields was sent this cycle |
| cur_icnt | output | CNT_W | Live halfword count |
| cur_hist | output | HIST_W | Live history with its marker bit |
| snap_valid | output | 1 | Snapshot pulse after an ack |
| snap_icnt | output | CNT_W | Count captured at ack |
| snap_hist | output | HIST_W | History captured at ack |
| rf_valid | output | 1 | Resource-full report pulse |
| rf_code | output | 1 | Reason: 0 counter, 1 history |
| rf_icnt | output | CNT_W | Count carried by a code-0 report |
| rf_hist | output | HIST_W | History carried by a code-1 report |

## Verification
The bench uses a small counter and a small history register so that both limits are reached often. Random retire sizes, instruction types and ack timing test whether the count and the shift order are right, and whether the snapshot is taken before or after the current cycle's instruction. A directed run lines up both limits on the same cycle to expose the order of the two reports. Further directed cases show that an ack next to the limit suppresses the report, and that a start with retire and ack both raised changes nothing but the clear.

// File: rtl/flow_track.sv
module flow_track #(
  parameter int CNT_W  = 16,
  parameter int HIST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_start,
  input  logic              ret_valid,
  input  logic              ret_len32,
  input  logic [3:0]        ret_kind,
  input  logic              msg_ack,
  output logic [CNT_W-1:0]  cur_icnt,
  output logic [HIST_W-1:0] cur_hist,
  output logic              snap_valid,
  output logic [CNT_W-1:0]  snap_icnt,
  output logic [HIST_W-1:0] snap_hist,
  output logic              rf_valid,
  output logic              rf_code,
  output logic [CNT_W-1:0]  rf_icnt,
  output logic [HIST_W-1:0] rf_hist
);

  localparam logic [CNT_W:0]  LIMIT    = {1'b0, {CNT_W{1'b1}}} - 1'b1;
  localparam logic [HIST_W-1:0] HIST_INIT = {{(HIST_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  icnt_q;
  logic [HIST_W-1:0] hist_q;
  logic              pend_q;
  logic [HIST_W-1:0] pend_hist_q;

  wire              is_br     = ret_valid && (ret_kind == 4'd4 || ret_kind == 4'd5);
  wire [CNT_W:0]    inc       = ret_valid ? (ret_len32 ? 2 : 1) : 0;
  wire [CNT_W-1:0]  base_cnt  = msg_ack ? '0 : icnt_q;
  wire [HIST_W-1:0] base_hist = msg_ack ? HIST_INIT : hist_q;
  wire [CNT_W:0]    sum       = {1'b0, base_cnt} + inc;
  wire [HIST_W-1:0] hist_sh   = is_br ? {base_hist[HIST_W-2:0], ret_kind[0]} : base_hist;
  wire              cnt_full  = sum >= LIMIT;
  wire              hist_full = hist_sh[HIST_W-1];

  assign cur_icnt = icnt_q;
  assign cur_hist = hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q      <= '0;
      hist_q      <= HIST_INIT;
      pend_q      <= 1'b0;
      pend_hist_q <= '0;
      snap_valid  <= 1'b0;
      snap_icnt   <= '0;
      snap_hist   <= '0;
      rf_valid    <= 1'b0;
      rf_code     <= 1'b0;
      rf_icnt     <= '0;
      rf_hist     <= '0;
    end else if (trace_start) begin
      icnt_q      <= '0;
      hist_q      <= HIST_INIT;
      pend_q      <= 1'b0;
      pend_hist_q <= '0;
      snap_valid  <= 1'b0;
      rf_valid    <= 1'b0;
    end else begin
      icnt_q     <= cnt_full ? '0 : sum[CNT_W-1:0];
      hist_q     <= hist_full ? HIST_INIT : hist_sh;
      snap_valid <= msg_ack;
      if (msg_ack) begin
        snap_icnt <= icnt_q;
        snap_hist <= hist_q;
      end
      pend_q <= !pend_q && cnt_full && hist_full;
      if (cnt_full && hist_full) pend_hist_q <= hist_sh;
      if (pend_q) begin
        rf_valid <= 1'b1;
        rf_code  <= 1'b1;
        rf_icnt  <= '0;
        rf_hist  <= pend_hist_q;
      end else if (cnt_full) begin
        rf_valid <= 1'b1;
        rf_code  <= 1'b0;
        rf_icnt  <= sum[CNT_W-1:0];
        rf_hist  <= '0;
      end else if (hist_full) begin
        rf_valid <= 1'b1;
        rf_code  <= 1'b1;
        rf_icnt  <= '0;
        rf_hist  <= hist_sh;
      end else begin
        rf_valid <= 1'b0;
      end
    end
  end

  AST_HIST_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q != '0 && !hist_q[HIST_W-1]);  // R2
  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, icnt_q} < LIMIT);  // R4
  AST_HIST_REPORT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && rf_code |-> rf_hist[HIST_W-1]);  // R5
  AST_DOUBLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && !rf_code && pend_q && !trace_start |=> rf_valid && rf_code);  // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trace_start |=> icnt_q == '0 && hist_q == HIST_INIT && !rf_valid && !snap_valid);  // R7
  AST_ACK_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack && !trace_start && !pend_q |=> !rf_valid && icnt_q <= 2);  // R8

endmodule

// File: tb/sim_flow_track.sv
`timescale 1ns/1ps
module sim_flow_track;
  localparam int CW = 5;
  localparam int HW = 6;
  localparam longint LIM = (64'd1 << CW) - 2;

  logic clk = 0, rst_n = 0;
  logic trace_start = 0, ret_valid = 0, ret_len32 = 0, msg_ack = 0;
  logic [3:0] ret_kind = 0;
  logic [CW-1:0] cur_icnt, snap_icnt, rf_icnt;
  logic [HW-1:0] cur_hist, snap_hist, rf_hist;
  logic snap_valid, rf_valid, rf_code;

  int total = 0, bad = 0;
  bit done = 0;

  longint m_icnt, m_hist, m_pendh;
  bit m_pend;
  bit e_sv, e_rv, e_rc;
  longint e_si, e_sh, e_ri, e_rh;

  always #2.5 clk = ~clk;

  flow_track #(.CNT_W(CW), .HIST_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_start(trace_start), .ret_valid(ret_valid),
    .ret_len32(ret_len32), .ret_kind(ret_kind), .msg_ack(msg_ack),
    .cur_icnt(cur_icnt), .cur_hist(cur_hist), .snap_valid(snap_valid),
    .snap_icnt(snap_icnt), .snap_hist(snap_hist), .rf_valid(rf_valid),
    .rf_code(rf_code), .rf_icnt(rf_icnt), .rf_hist(rf_hist));

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint add_of(input bit v, input bit l32);
    return v ? (l32 ? 2 : 1) : 0;
  endfunction

  task automatic model(input bit st, input bit v, input bit l32, input logic [3:0] k, input bit ack);
    longint bc, bh, s, hs;
    bit cf, hf;
    if (st) begin
      m_icnt = 0; m_hist = 1; m_pend = 0; e_sv = 0; e_rv = 0;
      return;
    end
    bc = ack ? 0 : m_icnt;
    bh = ack ? 1 : m_hist;
    s  = bc + add_of(v, l32);
    hs = (v && (k == 4 || k == 5)) ? (((bh << 1) | (k == 5 ? 1 : 0)) & ((64'd1 << HW) - 1)) : bh;
    cf = s >= LIM;
    hf = hs[HW-1];
    e_sv = ack;
    if (ack) begin e_si = m_icnt; e_sh = m_hist; end
    if (m_pend) begin e_rv = 1; e_rc = 1; e_rh = m_pendh; end
    else if (cf) begin e_rv = 1; e_rc = 0; e_ri = s; end
    else if (hf) begin e_rv = 1; e_rc = 1; e_rh = hs; end
    else e_rv = 0;
    if (cf && hf) m_pendh = hs;
    m_pend = !m_pend && cf && hf;
    m_icnt = cf ? 0 : s;
    m_hist = hf ? 1 : hs;
  endtask

  task automatic compare();
    chk("R1 cur_icnt", cur_icnt, m_icnt);
    chk("R2 cur_hist", cur_hist, m_hist);
    chk("R3 snap_valid", snap_valid, e_sv);
    if (e_sv) begin
      chk("R3 snap_icnt", snap_icnt, e_si);
      chk("R3 snap_hist", snap_hist, e_sh);
    end
    chk("R4/R5 rf_valid", rf_valid, e_rv);
    if (e_rv) begin
      chk("R4/R5 rf_code", rf_code, e_rc);
      if (e_rc) chk("R5 rf_hist", rf_hist, e_rh);
      else      chk("R4 rf_icnt", rf_icnt, e_ri);
    end
  endtask

  task automatic cyc(input bit st, input bit v, input bit l32, input logic [3:0] k, input bit ack);
    trace_start = st; ret_valid = v; ret_len32 = l32; ret_kind = k; msg_ack = ack;
    @(posedge clk);
    model(st, v, l32, k, ack);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_icnt = 0; m_hist = 1; m_pend = 0; m_pendh = 0;
    e_sv = 0; e_rv = 0; e_rc = 0; e_si = 0; e_sh = 0; e_ri = 0; e_rh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset icnt", cur_icnt, 0);
    chk("R9 reset hist", cur_hist, 1);
    chk("R9 reset snap_valid", snap_valid, 0);
    chk("R9 reset rf_valid", rf_valid, 0);

    // R6: both limits on the same cycle
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 4'd5, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 4'd1, 0);
    cyc(0, 1, 1, 4'd4, 0);
    chk("R6 first code", {rf_valid, rf_code}, 2'b10);
    chk("R6 first icnt", rf_icnt, 30);
    cyc(0, 0, 0, 0, 0);
    chk("R6 second code", {rf_valid, rf_code}, 2'b11);
    chk("R6 second hist", rf_hist, 6'b111110);
    cyc(0, 0, 0, 0, 0);
    chk("R6 no third", rf_valid, 0);

    // R8: ack right at the limit
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) cyc(0, 1, 1, 4'd0, 0);
    chk("R8 setup", cur_icnt, 28);
    cyc(0, 1, 1, 4'd0, 1);
    chk("R8 no report", rf_valid, 0);
    chk("R8 new interval", cur_icnt, 2);
    chk("R8 snapshot", snap_icnt, 28);

    // R7: start with retire and ack raised
    cyc(0, 1, 0, 4'd5, 0);
    cyc(0, 1, 1, 4'd4, 1);
    cyc(0, 1, 1, 4'd5, 0);
    cyc(1, 1, 1, 4'd5, 1);
    chk("R7 icnt", cur_icnt, 0);
    chk("R7 hist", cur_hist, 1);
    chk("R7 snap", snap_valid, 0);
    chk("R7 rf", rf_valid, 0);

    // R1/R2: other types, idle
    cyc(0, 0, 1, 4'd5, 0);
    chk("R1 idle holds", cur_icnt, 0);
    cyc(0, 1, 0, 4'd9, 0);
    chk("R2 other type", cur_hist, 1);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] k = ($urandom_range(0, 2) != 0) ? 4'($urandom_range(4, 5)) : 4'($urandom_range(0, 15));
      cyc(r < 1, $urandom_range(0, 4) != 0, $urandom_range(0, 1) != 0, k, r >= 1 && r < 8);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule